// File: doc/BRIEF.md
# Multi-Core Halt Power-State Controller

This block tracks the idle state of a processor package built from several cores. Each core signals when it executes a halt-type instruction, and the block keeps one halted flag per core. Interrupt-class events clear that core's flag: a system-management interrupt, bus init, init, a non-maskable or maskable local interrupt line, or an interrupt message from the system bus. From these flags and a stop-clock input it derives one package state. The states are Normal, Halt, Stop-Grant, Entering deep idle, Deep idle and Exiting.

The deep idle state is used only when every core is halted and the enable input is set. On entry the block lowers the core frequency ratio first, waits a programmable settle count, and only then lowers the voltage ID. Exit runs the same steps in reverse. A woken core is released only after the ratio is back at its high value. A wake that arrives during entry aborts the entry from the step it has reached. Stop-clock taken during Halt parks the package in Stop-Grant, and the package goes back to Halt when stop-clock is released. Two status outputs show when bus snoops may be serviced and when interrupts may be serviced.

Top module: `halt_pm_ctrl`

## Requirements
- R1: A pulse on `halt_req_i[i]` sets only core i's halted flag, and the flag shows on `core_halted_o` after the next clock edge. The package state is encoded as 0 Normal, 1 Halt, 2 Stop-Grant, 3 Entering, 4 Deep idle, 5 Exiting. With at least one core halted and no deep idle, the state is 1. With no core halted, it is 0.
- R2: Any one of `smi_i`, `binit_i`, `init_i`, `nmi_i`, `intr_i` or `bus_irq_i` on bit i clears core i's halted flag at the next edge. The other flags are unchanged.
- R3: When a halt request and a wake event reach the same core in the same cycle, the wake wins and the flag ends up clear.
- R4: An active-low `rst_ni` clears all flags, sets the state to 0 and sets `ratio_low_o` and `vid_low_o` to 0 at once, without waiting for a clock edge.
- R5: `stpclk_i` high in state 1 moves the package to state 2 at the next edge. While in state 2, `stpclk_i` low returns the package to state 1. `stpclk_i` in state 0 has no effect.
- R6: In state 2, halt requests and wake events are ignored, and `core_halted_o` holds its value.
- R7: The package leaves state 1 for state 3 only if all flags are set and `ehalt_en_i` is 1. With the enable at 0, all cores halted keeps the package in state 1.
- R8: On entry, `ratio_low_o` rises at the same edge that state 3 starts. `vid_low_o` rises `settle_i`+1 cycles later. State 4 follows `settle_i`+1 cycles after that, with both outputs high. `vid_low_o` is never high while `ratio_low_o` is low.
- R9: A wake in state 4 moves the package to state 5 and drops `vid_low_o` at the same edge. `ratio_low_o` falls `settle_i`+1 cycles later. The woken cores' flags clear `settle_i`+1 cycles after that. The state then becomes 1 if other cores are still halted, otherwise 0.
- R10: A wake in state 3 before `vid_low_o` has risen drops `ratio_low_o` at once and leaves `vid_low_o` low. The woken core is released `settle_i`+1 cycles later.
- R11: `rsm_i[i]` marks core i's return from the management handler. If `rsm_to_halt_i[i]` is 1, core i's flag is set. If it is 0, the flag is unchanged.
- R12: `snoop_ok_o` is 1 in states 0, 1, 2 and 4 and is 0 in states 3 and 5. `irq_ok_o` is 1 only in states 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | N_CORES | Per-core halt or monitor-wait executed |
| smi_i | input | N_CORES | Per-core system-management interrupt |
| binit_i | input | N_CORES | Per-core bus init |
| init_i | input | N_CORES | Per-core init |
| nmi_i | input | N_CORES | Per-core non-maskable local interrupt |
| intr_i | input | N_CORES | Per-core maskable local interrupt |
| bus_irq_i | input | N_CORES | Per-core interrupt message from the system bus |
| rsm_i | input | N_CORES | Per-core return from management handler |
| rsm_to_halt_i | input | N_CORES | Per-core: return lands in Halt |
| stpclk_i | input | 1 | Stop-clock request |
| ehalt_en_i | input | 1 | Deep idle enable |
| settle_i | input | CNT_W | Settle wait per ratio/voltage step |
| core_halted_o | output | N_CORES | Per-core halted flags |
| pkg_state_o | output | 3 | Package state code |
| ratio_low_o | output | 1 | Low core-to-bus ratio selected |
| vid_low_o | output | 1 | Low voltage ID selected |
| snoop_ok_o | output | 1 | Bus snoops may be serviced |
| irq_ok_o | output | 1 | Interrupts may be serviced |

## Verification
A halt request and a wake event can reach the same core in the same clock cycle. The flag update must then favour the wake. The stimulus table drives both on one core in one cycle while a second core stays halted. It then checks that the first core's flag stays clear and that the package state still reflects the second core. A related case is a wake that lands while the entry sequence is partway through. There the abort must win over the next settle step: this is judged by checking that the voltage output never rises and by counting cycles until the core is released.

// File: rtl/halt_pm_pkg.sv
package halt_pm_pkg;
  typedef enum logic [2:0] {
    PS_NORMAL = 3'd0,
    PS_HALT   = 3'd1,
    PS_STOPG  = 3'd2,
    PS_ENTER  = 3'd3,
    PS_DEEP   = 3'd4,
    PS_EXIT   = 3'd5
  } pkg_state_e;
endpackage

// File: rtl/core_event_merge.sv
module core_event_merge #(
  parameter int N_CORES = 4
) (
  input  logic [N_CORES-1:0] halt_req_i,
  input  logic [N_CORES-1:0] smi_i,
  input  logic [N_CORES-1:0] binit_i,
  input  logic [N_CORES-1:0] init_i,
  input  logic [N_CORES-1:0] nmi_i,
  input  logic [N_CORES-1:0] intr_i,
  input  logic [N_CORES-1:0] bus_irq_i,
  input  logic [N_CORES-1:0] rsm_i,
  input  logic [N_CORES-1:0] rsm_to_halt_i,
  output logic [N_CORES-1:0] halt_set_o,
  output logic [N_CORES-1:0] wake_o
);
  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    assign wake_o[i]     = smi_i[i] | binit_i[i] | init_i[i] |
                           nmi_i[i] | intr_i[i]  | bus_irq_i[i];
    // handler return may land back in halt
    assign halt_set_o[i] = halt_req_i[i] | (rsm_i[i] & rsm_to_halt_i[i]);
  end
endmodule

// File: rtl/halt_flags.sv
module halt_flags #(
  parameter int N_CORES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_CORES-1:0] set_i,
  input  logic [N_CORES-1:0] clr_i,
  output logic [N_CORES-1:0] q_o
);
  for (genvar i = 0; i < N_CORES; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (en_i) begin
        if (clr_i[i])      q_o[i] <= 1'b0;  // wake beats halt
        else if (set_i[i]) q_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/halt_pm_ctrl.sv
module halt_pm_ctrl
  import halt_pm_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CORES-1:0] halt_req_i,
  input  logic [N_CORES-1:0] smi_i,
  input  logic [N_CORES-1:0] binit_i,
  input  logic [N_CORES-1:0] init_i,
  input  logic [N_CORES-1:0] nmi_i,
  input  logic [N_CORES-1:0] intr_i,
  input  logic [N_CORES-1:0] bus_irq_i,
  input  logic [N_CORES-1:0] rsm_i,
  input  logic [N_CORES-1:0] rsm_to_halt_i,
  input  logic               stpclk_i,
  input  logic               ehalt_en_i,
  input  logic [CNT_W-1:0]   settle_i,
  output logic [N_CORES-1:0] core_halted_o,
  output logic [2:0]         pkg_state_o,
  output logic               ratio_low_o,
  output logic               vid_low_o,
  output logic               snoop_ok_o,
  output logic               irq_ok_o
);
  pkg_state_e state_q, state_d;
  logic ratio_q, ratio_d, vid_q, vid_d;
  logic [N_CORES-1:0] pend_q, pend_d;
  logic [N_CORES-1:0] halt_set, wake, nxt_flags;
  logic [N_CORES-1:0] flag_set, flag_clr;
  logic flag_en, tmr_load, tmr_done;

  core_event_merge #(.N_CORES(N_CORES)) u_merge (
    .halt_req_i   (halt_req_i),
    .smi_i        (smi_i),
    .binit_i      (binit_i),
    .init_i       (init_i),
    .nmi_i        (nmi_i),
    .intr_i       (intr_i),
    .bus_irq_i    (bus_irq_i),
    .rsm_i        (rsm_i),
    .rsm_to_halt_i(rsm_to_halt_i),
    .halt_set_o   (halt_set),
    .wake_o       (wake)
  );

  halt_flags #(.N_CORES(N_CORES)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (flag_en),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (core_halted_o)
  );

  settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (settle_i),
    .done_o(tmr_done)
  );

  assign nxt_flags = (core_halted_o | halt_set) & ~wake;

  always_comb begin
    state_d  = state_q;
    ratio_d  = ratio_q;
    vid_d    = vid_q;
    pend_d   = pend_q;
    flag_en  = 1'b0;
    flag_set = '0;
    flag_clr = '0;
    tmr_load = 1'b0;
    unique case (state_q)
      PS_NORMAL, PS_HALT: begin
        if (stpclk_i && |core_halted_o) begin
          state_d = PS_STOPG;
        end else begin
          flag_en  = 1'b1;
          flag_set = halt_set;
          flag_clr = wake;
          if (&nxt_flags && ehalt_en_i) begin
            state_d  = PS_ENTER;
            ratio_d  = 1'b1;          // ratio step first
            tmr_load = 1'b1;
          end else begin
            state_d = (|nxt_flags) ? PS_HALT : PS_NORMAL;
          end
        end
      end
      PS_STOPG: begin
        if (!stpclk_i) state_d = PS_HALT;
      end
      PS_ENTER: begin
        if (|wake) begin
          // abort: unwind from the current step
          state_d  = PS_EXIT;
          pend_d   = wake;
          tmr_load = 1'b1;
          if (vid_q) vid_d   = 1'b0;
          else       ratio_d = 1'b0;
        end else if (tmr_done) begin
          if (!vid_q) begin
            vid_d    = 1'b1;
            tmr_load = 1'b1;
          end else begin
            state_d = PS_DEEP;
          end
        end
      end
      PS_DEEP: begin
        if (|wake) begin
          state_d  = PS_EXIT;
          pend_d   = wake;
          vid_d    = 1'b0;            // voltage restored first
          tmr_load = 1'b1;
        end
      end
      PS_EXIT: begin
        pend_d = pend_q | wake;
        if (tmr_done) begin
          if (ratio_q) begin
            ratio_d  = 1'b0;
            tmr_load = 1'b1;
          end else begin
            flag_en  = 1'b1;
            flag_clr = pend_q | wake;
            pend_d   = '0;
            state_d  = (|(core_halted_o & ~(pend_q | wake))) ? PS_HALT : PS_NORMAL;
          end
        end
      end
      default: state_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_NORMAL;
      ratio_q <= 1'b0;
      vid_q   <= 1'b0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      ratio_q <= ratio_d;
      vid_q   <= vid_d;
      pend_q  <= pend_d;
    end
  end

  assign pkg_state_o = state_q;
  assign ratio_low_o = ratio_q;
  assign vid_low_o   = vid_q;
  assign snoop_ok_o  = (state_q != PS_ENTER) && (state_q != PS_EXIT);
  assign irq_ok_o    = (state_q == PS_NORMAL) || (state_q == PS_HALT);
endmodule

// File: rtl/halt_pm_chk.sv
module halt_pm_chk #(
  parameter int N_CORES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stpclk_i,
  input logic               ehalt_en_i,
  input logic [N_CORES-1:0] core_halted_o,
  input logic [2:0]         pkg_state_o,
  input logic               ratio_low_o,
  input logic               vid_low_o,
  input logic               snoop_ok_o
);
  a_r8_vid_needs_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_low_o |-> ratio_low_o);

  a_r8_vid_rise_after_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_low_o) |-> $past(ratio_low_o));

  a_r8_deep_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_state_o == 3'd4) |-> (ratio_low_o && vid_low_o));

  a_r9_ratio_fall_after_vid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ratio_low_o) |-> (!vid_low_o && !$past(vid_low_o)));

  a_r5_stopg_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_state_o == 3'd2 && !stpclk_i) |=> (pkg_state_o == 3'd1));

  a_r6_stopg_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_state_o == 3'd2) |=> $stable(core_halted_o));

  a_r7_enter_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_state_o == 3'd3 && $past(pkg_state_o) != 3'd3)
      |-> ($past(ehalt_en_i) && (&core_halted_o)));

  a_r12_snoop_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_state_o == 3'd1 || pkg_state_o == 3'd4) |-> snoop_ok_o);

  a_r1_state_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkg_state_o <= 3'd5);
endmodule

bind halt_pm_ctrl halt_pm_chk #(.N_CORES(N_CORES)) u_halt_pm_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stpclk_i     (stpclk_i),
  .ehalt_en_i   (ehalt_en_i),
  .core_halted_o(core_halted_o),
  .pkg_state_o  (pkg_state_o),
  .ratio_low_o  (ratio_low_o),
  .vid_low_o    (vid_low_o),
  .snoop_ok_o   (snoop_ok_o)
);

// File: tb/halt_pm_ctrl_bench.sv
module halt_pm_ctrl_bench;
  localparam int N = 4;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] halt_req_i = '0, smi_i = '0, binit_i = '0, init_i = '0;
  logic [N-1:0] nmi_i = '0, intr_i = '0, bus_irq_i = '0, rsm_i = '0, rsm_to_halt_i = '0;
  logic stpclk_i = 1'b0, ehalt_en_i = 1'b0;
  logic [W-1:0] settle_i = 16'd3;
  logic [N-1:0] core_halted_o;
  logic [2:0] pkg_state_o;
  logic ratio_low_o, vid_low_o, snoop_ok_o, irq_ok_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  halt_pm_ctrl #(.N_CORES(N), .CNT_W(W)) u_halt_pm_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_req_i(halt_req_i), .smi_i(smi_i),
    .binit_i(binit_i), .init_i(init_i), .nmi_i(nmi_i), .intr_i(intr_i),
    .bus_irq_i(bus_irq_i), .rsm_i(rsm_i), .rsm_to_halt_i(rsm_to_halt_i),
    .stpclk_i(stpclk_i), .ehalt_en_i(ehalt_en_i), .settle_i(settle_i),
    .core_halted_o(core_halted_o), .pkg_state_o(pkg_state_o),
    .ratio_low_o(ratio_low_o), .vid_low_o(vid_low_o),
    .snoop_ok_o(snoop_ok_o), .irq_ok_o(irq_ok_o)
  );

  // {halt[15:12], wake(intr)[11:8], stpclk[7], exp_flags[6:3], exp_state[2:0]}
  localparam logic [15:0] VEC [11] = '{
    {4'b0001, 4'b0000, 1'b0, 4'b0001, 3'd1},  // R1
    {4'b0100, 4'b0000, 1'b0, 4'b0101, 3'd1},  // R1
    {4'b0000, 4'b0001, 1'b0, 4'b0100, 3'd1},  // R2
    {4'b0010, 4'b0010, 1'b0, 4'b0100, 3'd1},  // R3
    {4'b0000, 4'b0000, 1'b1, 4'b0100, 3'd2},  // R5
    {4'b1000, 4'b0100, 1'b1, 4'b0100, 3'd2},  // R6
    {4'b0000, 4'b0000, 1'b0, 4'b0100, 3'd1},  // R5
    {4'b1011, 4'b0000, 1'b0, 4'b1111, 3'd1},  // R7
    {4'b0000, 4'b1111, 1'b0, 4'b0000, 3'd0},  // R2
    {4'b0000, 4'b0000, 1'b1, 4'b0000, 3'd0},  // R5
    {4'b0000, 4'b0000, 1'b0, 4'b0000, 3'd0}   // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic clear_ev();
    halt_req_i = '0; smi_i = '0; binit_i = '0; init_i = '0; nmi_i = '0;
    intr_i = '0; bus_irq_i = '0; rsm_i = '0; rsm_to_halt_i = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    bit vid_seen;
    tick(); tick();
    rst_ni = 1'b1;
    // R4 reset state
    check("R4 flags", core_halted_o, 0);
    check("R4 state", pkg_state_o, 0);
    check("R4 ratio", ratio_low_o, 0);
    check("R4 vid", vid_low_o, 0);
    check("R12 snoop normal", snoop_ok_o, 1);
    check("R12 irq normal", irq_ok_o, 1);

    for (int k = 0; k < 11; k++) begin
      halt_req_i = VEC[k][15:12];
      intr_i     = VEC[k][11:8];
      stpclk_i   = VEC[k][7];
      tick();
      check($sformatf("R1/R2/R3/R5/R6/R7 vec%0d flags", k), core_halted_o, VEC[k][6:3]);
      check($sformatf("R1/R5 vec%0d state", k), pkg_state_o, VEC[k][2:0]);
      if (VEC[k][2:0] == 3'd2) begin
        check("R12 snoop stopg", snoop_ok_o, 1);
        check("R12 irq stopg", irq_ok_o, 0);
      end
      clear_ev();
    end
    stpclk_i = 1'b0;

    // R2: each wake source
    for (int s = 0; s < 6; s++) begin
      halt_req_i = 4'b1111; tick(); clear_ev();
      case (s)
        0: smi_i = 4'b0010;
        1: binit_i = 4'b0010;
        2: init_i = 4'b0010;
        3: nmi_i = 4'b0010;
        4: intr_i = 4'b0010;
        default: bus_irq_i = 4'b0010;
      endcase
      tick(); clear_ev();
      check($sformatf("R2 source%0d", s), core_halted_o, 4'b1101);
      intr_i = 4'b1111; tick(); clear_ev();
    end

    // R11
    rsm_i = 4'b0100; rsm_to_halt_i = 4'b0100; tick(); clear_ev();
    check("R11 resume to halt", core_halted_o, 4'b0100);
    rsm_i = 4'b1000; rsm_to_halt_i = 4'b0000; tick(); clear_ev();
    check("R11 resume to normal", core_halted_o, 4'b0100);
    intr_i = 4'b0100; tick(); clear_ev();

    // R7/R8 entry
    ehalt_en_i = 1'b1; settle_i = 16'd3;
    halt_req_i = 4'b0111; tick(); clear_ev();
    check("R7 partial halt", pkg_state_o, 1);
    halt_req_i = 4'b1000; tick(); clear_ev();
    check("R7 enter state", pkg_state_o, 3);
    check("R8 ratio first", ratio_low_o, 1);
    check("R8 vid still high", vid_low_o, 0);
    check("R12 snoop enter", snoop_ok_o, 0);
    check("R12 irq enter", irq_ok_o, 0);
    n = 0;
    do begin tick(); n++; end while (!vid_low_o && n < 50);
    check("R8 ratio-to-vid gap", n, 4);
    n = 0;
    do begin tick(); n++; end while (pkg_state_o != 3'd4 && n < 50);
    check("R8 vid-to-deep gap", n, 4);
    check("R8 deep levels", {ratio_low_o, vid_low_o}, 2'b11);
    check("R12 snoop deep", snoop_ok_o, 1);
    tick();
    check("R8 deep holds", pkg_state_o, 4);

    // R9 exit
    nmi_i = 4'b0010; tick(); clear_ev();
    check("R9 exit state", pkg_state_o, 5);
    check("R9 vid restored first", {ratio_low_o, vid_low_o}, 2'b10);
    check("R9 core not yet released", core_halted_o, 4'b1111);
    n = 0;
    do begin tick(); n++; end while (ratio_low_o && n < 50);
    check("R9 vid-to-ratio gap", n, 4);
    n = 0;
    do begin tick(); n++; end while (core_halted_o[1] && n < 50);
    check("R9 ratio-to-release gap", n, 4);
    check("R9 flags after release", core_halted_o, 4'b1101);
    check("R9 back to halt", pkg_state_o, 1);

    // R10 abort during ratio step
    settle_i = 16'd5;
    halt_req_i = 4'b0010; tick(); clear_ev();
    check("R10 entering", pkg_state_o, 3);
    tick();
    bus_irq_i = 4'b0001; tick(); clear_ev();
    check("R10 abort state", pkg_state_o, 5);
    check("R10 ratio dropped", ratio_low_o, 0);
    vid_seen = vid_low_o;
    n = 0;
    do begin tick(); n++; vid_seen |= vid_low_o; end while (core_halted_o[0] && n < 50);
    check("R10 release gap", n, 6);
    check("R10 vid never low", vid_seen, 0);
    check("R10 flags", core_halted_o, 4'b1110);
    check("R10 state", pkg_state_o, 1);

    // R4 asynchronous reset mid-cycle
    ehalt_en_i = 1'b0;
    #5 rst_ni = 1'b0;
    #1;
    check("R4 async flags", core_halted_o, 0);
    check("R4 async state", pkg_state_o, 0);
    tick();
    rst_ni = 1'b1;
    tick();
    check("R4 after release", pkg_state_o, 0);

    finish_run();
  end
endmodule